// File: doc/BRIEF.md
# Serial Command Arithmetic Controller

This block is a byte-stream command interpreter. It sits between a byte-wide serial receiver and transmitter pair and a small arithmetic operator. The operator adds or subtracts, and the function it holds can be switched while the system runs. Each received byte is taken as a command. A query returns a letter that names the loaded function. A compute command collects two hexadecimal digits, drives them into the operator with an instruction code, and sends the signed 8-bit result back as text. Any byte the controller cannot use triggers an error message, after which the controller reads a fresh operand pair and computes with it.

The operator is modelled behaviourally inside the block. The `flavour_sel` input stands in for the operator that is currently loaded, where 0 is the adder and 1 is the subtractor. The receive side hands over one byte at a time: `rx_valid` is held high until the block pulses `rx_ack`. The transmit side takes one byte for each `tx_we` pulse and reports `tx_busy` while it is serialising.

Top module: `cmdalu_ctrl`

## Requirements
- R1: After synchronous reset, including a reset in the middle of a command, `tx_we` and `rx_ack` are low and the controller is idle, ready for a new command.
- R2: A byte is accepted only while `rx_valid` is high, and each accepted byte is acknowledged by a single-cycle `rx_ack` pulse.
- R3: The command byte 0x3F ('?') is answered with 0x41 ('A') when the adder is loaded or 0x53 ('S') when the subtractor is loaded, followed by 0x0D.
- R4: The command byte 0x63 ('c'), followed by two operand digits from '0'-'9' or 'A'-'F' (operand A first), returns A+B with the adder loaded.
- R5: With the subtractor loaded, the same sequence returns A-B as 8-bit two's complement. For example, 3 and 5 give "FE".
- R6: Every result is sent as two upper-case hex characters, high nibble first, then 0x0D. A command byte other than '?' or 'c' produces "ERROR" plus 0x0D. The controller then reads two operand digits and returns their result as in R4/R5.
- R7: An operand byte outside '0'-'9' and 'A'-'F' (lower case included) produces the error message, followed by a fresh operand pair as in R6.
- R8: `tx_we` is never raised in a cycle that follows a cycle with `tx_busy` high, and it is never high in two consecutive cycles.
- R9: `rx_ack` is never high in two consecutive cycles, and each byte offered is acknowledged exactly once.
- R10: A change of `flavour_sel` between commands takes effect on the next query or computation.
- R11: With no byte offered, the controller transmits nothing and acknowledges nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flavour_sel | input | 1 | Loaded operator function: 0 add, 1 subtract |
| rx_valid | input | 1 | A received byte is waiting |
| rx_data | input | 8 | Received byte |
| rx_ack | output | 1 | One-cycle pulse: the byte has been taken |
| tx_busy | input | 1 | Transmitter is still sending a byte |
| tx_we | output | 1 | One-cycle pulse: send `tx_byte` |
| tx_byte | output | 8 | Byte to transmit |

## Verification
The hardest states to reach are the recovery paths inside a command. One is an illegal digit that arrives after a valid first operand has already been loaded. The other is a reset that lands while the controller waits for the second operand. The stimulus table includes sequences such as "cAa11", which the controller must reject midway and then finish with the replacement pair. A directed test stops a command after "c1", asserts reset, and then checks that a query is answered cleanly. Runs with a slow and an instant transmitter check that strobe spacing respects `tx_busy`.

// File: rtl/cmdalu_pkg.sv
package cmdalu_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int RES_W  = 8;

  typedef enum logic [1:0] {
    INS_IDLE = 2'b00,
    INS_LDA  = 2'b01,
    INS_LDB  = 2'b10,
    INS_EXE  = 2'b11
  } ins_e;

  // error message states are contiguous and followed by the operand reads
  typedef enum logic [4:0] {
    ST_IDLE, ST_DECIDE,
    ST_Q_ID, ST_Q_CR, ST_Q_END,
    ST_C_GETA, ST_C_GETB, ST_C_EXEC, ST_C_WAIT, ST_C_TXH, ST_C_TXL, ST_C_TXCR,
    ST_E0, ST_E1, ST_E2, ST_E3, ST_E4, ST_E5, ST_E_GETA, ST_E_GETB
  } st_e;

  localparam logic [BYTE_W-1:0] ASC_QRY = 8'h3F;
  localparam logic [BYTE_W-1:0] ASC_CMP = 8'h63;
  localparam logic [BYTE_W-1:0] ASC_CR  = 8'h0D;
  localparam logic [BYTE_W-1:0] ASC_ADD = 8'h41;
  localparam logic [BYTE_W-1:0] ASC_SUB = 8'h53;

  function automatic logic is_hex(input logic [BYTE_W-1:0] b);
    return (b >= 8'h30 && b <= 8'h39) || (b >= 8'h41 && b <= 8'h46);
  endfunction

  function automatic logic [NIB_W-1:0] hex_val(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] t;
    if (b <= 8'h39) t = b - 8'h30;
    else            t = b - 8'h37;
    return t[NIB_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] hex_char(input logic [NIB_W-1:0] n);
    logic [BYTE_W-1:0] w;
    w = {{(BYTE_W-NIB_W){1'b0}}, n};
    return (n < 4'd10) ? (8'h30 + w) : (8'h37 + w);
  endfunction

endpackage

// File: rtl/cmdalu_operator.sv
module cmdalu_operator
  import cmdalu_pkg::*;
#(
  parameter int NW = NIB_W,
  parameter int RW = RES_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flavour_sel,
  input  ins_e                 instr,
  input  logic [NW-1:0]        data,
  output logic signed [RW-1:0] result,
  output logic                 id
);

  localparam int EXT = RW - NW;

  logic [NW-1:0] opa_q, opb_q;
  logic signed [RW-1:0] ea, eb;

  assign ea = $signed({{EXT{1'b0}}, opa_q});
  assign eb = $signed({{EXT{1'b0}}, opb_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      opa_q  <= '0;
      opb_q  <= '0;
      result <= '0;
      id     <= 1'b0;
    end else begin
      id <= flavour_sel;
      case (instr)
        INS_LDA: opa_q  <= data;
        INS_LDB: opb_q  <= data;
        INS_EXE: result <= id ? (ea - eb) : (ea + eb);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cmdalu_seq.sv
module cmdalu_seq
  import cmdalu_pkg::*;
#(
  parameter int NW = NIB_W,
  parameter int RW = RES_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rx_valid,
  input  logic [BYTE_W-1:0]          rx_data,
  output logic                       rx_ack,
  input  logic                       tx_busy,
  output logic                       tx_we,
  output logic [BYTE_W-1:0]          tx_byte,
  output ins_e                       op_instr,
  output logic [NW-1:0]              op_data,
  input  logic signed [RW-1:0]       op_result,
  input  logic                       op_id
);

  st_e               state;
  logic [BYTE_W-1:0] cmd_q;
  logic              rx_ok, tx_ok, dig_ok;

  // a byte still being acknowledged or sent blocks the next handshake
  assign rx_ok  = rx_valid && !rx_ack;
  assign tx_ok  = !tx_busy && !tx_we;
  assign dig_ok = is_hex(rx_data);

  function automatic logic [BYTE_W-1:0] err_char(input st_e s);
    case (s)
      ST_E0:   return 8'h45;
      ST_E1:   return 8'h52;
      ST_E2:   return 8'h52;
      ST_E3:   return 8'h4F;
      ST_E4:   return 8'h52;
      default: return ASC_CR;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cmd_q    <= '0;
      rx_ack   <= 1'b0;
      tx_we    <= 1'b0;
      tx_byte  <= '0;
      op_instr <= INS_IDLE;
      op_data  <= '0;
    end else begin
      rx_ack   <= 1'b0;
      tx_we    <= 1'b0;
      op_instr <= INS_IDLE;
      case (state)
        ST_IDLE: if (rx_ok) begin
          rx_ack <= 1'b1;
          cmd_q  <= rx_data;
          state  <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (cmd_q == ASC_QRY)      state <= ST_Q_ID;
          else if (cmd_q == ASC_CMP) state <= ST_C_GETA;
          else                       state <= ST_E0;
        end
        ST_Q_ID: if (tx_ok) begin
          tx_we   <= 1'b1;
          tx_byte <= op_id ? ASC_SUB : ASC_ADD;
          state   <= ST_Q_CR;
        end
        ST_Q_CR: if (tx_ok) begin
          tx_we   <= 1'b1;
          tx_byte <= ASC_CR;
          state   <= ST_Q_END;
        end
        ST_Q_END: state <= ST_IDLE;
        ST_C_GETA, ST_E_GETA: if (rx_ok) begin
          rx_ack <= 1'b1;
          if (dig_ok) begin
            op_instr <= INS_LDA;
            op_data  <= hex_val(rx_data);
            state    <= (state == ST_C_GETA) ? ST_C_GETB : ST_E_GETB;
          end else begin
            state <= ST_E0;
          end
        end
        ST_C_GETB, ST_E_GETB: if (rx_ok) begin
          rx_ack <= 1'b1;
          if (dig_ok) begin
            op_instr <= INS_LDB;
            op_data  <= hex_val(rx_data);
            state    <= ST_C_EXEC;
          end else begin
            state <= ST_E0;
          end
        end
        ST_C_EXEC: begin
          op_instr <= INS_EXE;
          state    <= ST_C_WAIT;
        end
        ST_C_WAIT: state <= ST_C_TXH;
        ST_C_TXH: if (tx_ok) begin
          tx_we   <= 1'b1;
          tx_byte <= hex_char(op_result[RW-1 -: NW]);
          state   <= ST_C_TXL;
        end
        ST_C_TXL: if (tx_ok) begin
          tx_we   <= 1'b1;
          tx_byte <= hex_char(op_result[NW-1:0]);
          state   <= ST_C_TXCR;
        end
        ST_C_TXCR: if (tx_ok) begin
          tx_we   <= 1'b1;
          tx_byte <= ASC_CR;
          state   <= ST_IDLE;
        end
        ST_E0, ST_E1, ST_E2, ST_E3, ST_E4, ST_E5: if (tx_ok) begin
          tx_we   <= 1'b1;
          tx_byte <= err_char(state);
          state   <= st_e'(state + 5'd1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmdalu_ctrl.sv
module cmdalu_ctrl
  import cmdalu_pkg::*;
#(
  parameter int NW = NIB_W,
  parameter int RW = RES_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flavour_sel,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ack,
  input  logic              tx_busy,
  output logic              tx_we,
  output logic [BYTE_W-1:0] tx_byte
);

  ins_e                 op_instr;
  logic [NW-1:0]        op_data;
  logic signed [RW-1:0] op_result;
  logic                 op_id;

  cmdalu_seq #(.NW(NW), .RW(RW)) u_seq (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ack(rx_ack),
    .tx_busy(tx_busy), .tx_we(tx_we), .tx_byte(tx_byte),
    .op_instr(op_instr), .op_data(op_data),
    .op_result(op_result), .op_id(op_id)
  );

  cmdalu_operator #(.NW(NW), .RW(RW)) u_op (
    .clk(clk), .rst(rst), .flavour_sel(flavour_sel),
    .instr(op_instr), .data(op_data),
    .result(op_result), .id(op_id)
  );

endmodule

// File: rtl/cmdalu_ctrl_chk.sv
module cmdalu_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_valid,
  input logic       rx_ack,
  input logic       tx_busy,
  input logic       tx_we,
  input logic [1:0] op_instr
);

  logic past_rst_q;

  always_ff @(posedge clk) begin
    past_rst_q <= rst;
    if (past_rst_q) begin
      assert_reset_quiet_R1: assert (!tx_we && !rx_ack)
        else $error("outputs active right after reset");
    end
  end

  assert_ack_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
    rx_ack |-> $past(rx_valid));

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (rst)
    rx_ack |=> !rx_ack);

  assert_tx_after_idle_R8: assert property (@(posedge clk) disable iff (rst)
    tx_we |-> $past(!tx_busy));

  assert_tx_single_R8: assert property (@(posedge clk) disable iff (rst)
    tx_we |=> !tx_we);

  // execute always follows the second operand load (R4)
  assert_exec_after_ldb_R4: assert property (@(posedge clk) disable iff (rst)
    (op_instr == 2'b11) |-> ($past(op_instr) == 2'b10));

endmodule

bind cmdalu_ctrl cmdalu_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ack(rx_ack),
  .tx_busy(tx_busy), .tx_we(tx_we), .op_instr(op_instr)
);

// File: tb/tb_cmdalu_ctrl.sv
module tb_cmdalu_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flavour_sel = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_ack;
  logic       tx_busy;
  logic       tx_we;
  logic [7:0] tx_byte;

  always #5 clk = ~clk;

  cmdalu_ctrl dut (
    .clk(clk), .rst(rst), .flavour_sel(flavour_sel),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ack(rx_ack),
    .tx_busy(tx_busy), .tx_we(tx_we), .tx_byte(tx_byte)
  );

  typedef struct packed {
    logic [31:0] tag;
    logic        flav;
    logic [2:0]  nin;
    logic [39:0] ins;
    logic [3:0]  nout;
    logic [79:0] outs;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{"R3  ", 1'b0, 3'd1, {"?", 32'h0},     4'd2, {"A", 8'h0D, 64'h0}},
    '{"R10 ", 1'b1, 3'd1, {"?", 32'h0},     4'd2, {"S", 8'h0D, 64'h0}},
    '{"R4  ", 1'b0, 3'd3, {"c35", 16'h0},   4'd3, {"08", 8'h0D, 56'h0}},
    '{"R5  ", 1'b1, 3'd3, {"c35", 16'h0},   4'd3, {"FE", 8'h0D, 56'h0}},
    '{"R4  ", 1'b0, 3'd3, {"cFF", 16'h0},   4'd3, {"1E", 8'h0D, 56'h0}},
    '{"R5  ", 1'b1, 3'd3, {"c0F", 16'h0},   4'd3, {"F1", 8'h0D, 56'h0}},
    '{"R6  ", 1'b0, 3'd3, {"x29", 16'h0},   4'd9, {"ERROR", 8'h0D, "0B", 8'h0D, 8'h00}},
    '{"R7  ", 1'b1, 3'd4, {"cg72", 8'h0},   4'd9, {"ERROR", 8'h0D, "05", 8'h0D, 8'h00}},
    '{"R7  ", 1'b0, 3'd5, "cAa11",          4'd9, {"ERROR", 8'h0D, "02", 8'h0D, 8'h00}},
    '{"R10 ", 1'b0, 3'd3, {"c9A", 16'h0},   4'd3, {"13", 8'h0D, 56'h0}}
  };

  // transmitter model and link monitors
  int         busy_len = 4;
  int         busy_cnt = 0;
  logic [7:0] log_mem [256];
  int         log_n = 0;
  int         ack_cnt = 0;
  int         viol_busy = 0;
  int         viol_we2 = 0;
  logic       prev_we = 1'b0;

  assign tx_busy = (busy_cnt != 0);

  always @(posedge clk) begin
    prev_we <= tx_we;
    if (rst) begin
      busy_cnt <= 0;
    end else begin
      if (tx_we && tx_busy) viol_busy <= viol_busy + 1;
      if (tx_we && prev_we) viol_we2 <= viol_we2 + 1;
      if (rx_ack) ack_cnt <= ack_cnt + 1;
      if (tx_we) begin
        if (log_n < 256) log_mem[log_n] <= tx_byte;
        log_n    <= log_n + 1;
        busy_cnt <= busy_len;
      end else if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  int checks = 0;
  int failures = 0;
  int sent_cnt = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (rx_ack) break;
    end
    rx_valid = 1'b0;
    sent_cnt++;
  endtask

  task automatic run_vec(input vec_t v);
    int start;
    @(negedge clk);
    flavour_sel = v.flav;
    repeat (3) @(negedge clk);
    start = log_n;
    for (int i = 0; i < int'(v.nin); i++) send_byte(v.ins[39-8*i -: 8]);
    for (int k = 0; k < 400 && (log_n - start) < int'(v.nout); k++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk((log_n - start) == int'(v.nout), string'(v.tag), log_n - start, int'(v.nout));
    for (int j = 0; j < int'(v.nout); j++)
      chk(log_mem[start+j] == v.outs[79-8*j -: 8], string'(v.tag),
          int'(log_mem[start+j]), int'(v.outs[79-8*j -: 8]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    failures++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int mark_log, mark_ack;
    repeat (3) @(negedge clk);
    chk(!tx_we && !rx_ack, "R1", {tx_we, rx_ack}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_we && !rx_ack, "R1", {tx_we, rx_ack}, 0);

    // R11: silence with no input
    mark_log = log_n;
    mark_ack = ack_cnt;
    repeat (50) @(negedge clk);
    chk(log_n == mark_log, "R11", log_n - mark_log, 0);
    chk(ack_cnt == mark_ack, "R11", ack_cnt - mark_ack, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: reset while waiting for the second operand, then a clean query
    send_byte("c");
    send_byte("1");
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(!tx_we && !rx_ack, "R1", {tx_we, rx_ack}, 0);
    run_vec('{"R1  ", 1'b0, 3'd1, {"?", 32'h0}, 4'd2, {"A", 8'h0D, 64'h0}});

    // R8: instant transmitter, error path back to back
    busy_len = 0;
    run_vec(VECS[6]);
    busy_len = 6;
    run_vec(VECS[3]);

    chk(viol_busy == 0, "R8", viol_busy, 0);
    chk(viol_we2 == 0, "R8", viol_we2, 0);
    chk(ack_cnt == sent_cnt, "R9", ack_cnt, sent_cnt);
    chk(!rx_ack && !tx_we, "R2", {rx_ack, tx_we}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule